// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Access-Right Check

This block holds recently used virtual-to-physical page translations and checks every memory reference against them. A lookup request carries a virtual page number, an address-space identifier and an access kind (read, write or execute). One clock after the request, the block raises exactly one of three results. A hit comes with the physical frame number. A miss means no entry holds the translation. A fault means an entry exists but refuses the access. Both miss and fault echo the virtual page and access kind, so that the miss handler or the exception logic can act on them.

An external table walker installs translations through a fill port. The block chooses the slot in hardware, and only the fill payload is given. A flush port drops every translation at once, or only those of one address space. Because each entry carries its address-space tag, a context switch needs no flush.

Top module: `tlb_top`

## Requirements
- R1: While reset is held and in the first cycle after it, the hit, miss and fault outputs are low, and `pfn` is zero. After reset no entry is occupied, so every lookup misses.
- R2: A lookup raised in cycle t with a matching, present and permitted entry gives `hit` high and that entry's frame on `pfn` in cycle t+1. `pfn` is zero whenever `hit` is low.
- R3: A lookup that matches no occupied entry gives `miss` in cycle t+1. `rspVpn` and `rspMode` then hold the requested page and access kind. Both are zero when neither miss nor fault is raised.
- R4: The access kind is encoded 00 read, 01 write, 10 execute and 11 reserved. A matching entry whose right for the requested kind is clear gives `fault` with the page and kind echoed. The reserved kind always faults on a match.
- R5: A matching entry installed with `fillPresent` low faults on every access kind.
- R6: An entry matches only when both its page number and its address-space identifier equal those of the lookup. The same page under different identifiers gives independent translations.
- R7: A fill whose page and identifier are not already held goes into the lowest-numbered unoccupied entry.
- R8: When all entries are occupied, a new fill evicts the entry under a rotating pointer, which starts at entry 0. If that entry was the one that last produced a hit, the next entry is taken instead. The pointer then moves one past the victim.
- R9: A fill whose page and identifier match an occupied entry overwrites that entry in place, so its new frame and rights take effect on the next lookup.
- R10: A flush with `flushAll` high empties every entry. With `flushAll` low it empties only the entries tagged `flushAsid`. The flush acts in a single cycle. A fill in the same cycle is applied after the flush and survives it.
- R11: At most one of hit, miss and fault is high in any cycle. Exactly one is high in the cycle after each lookup request, and none is high otherwise. A lookup issued with a fill or flush in the same cycle sees the contents from before them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| lkValid | input | 1 | Lookup request |
| lkVpn | input | VPN_W | Virtual page number to translate |
| lkAsid | input | ASID_W | Current address-space identifier |
| lkMode | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 reserved |
| fillValid | input | 1 | Install a translation |
| fillVpn | input | VPN_W | Page number of the new entry |
| fillAsid | input | ASID_W | Identifier of the new entry |
| fillPfn | input | PFN_W | Frame number of the new entry |
| fillRead | input | 1 | Read allowed |
| fillWrite | input | 1 | Write allowed |
| fillExec | input | 1 | Execute allowed |
| fillPresent | input | 1 | Page is mapped; low makes every access fault |
| flushValid | input | 1 | Flush request |
| flushAll | input | 1 | Flush every entry rather than one identifier |
| flushAsid | input | ASID_W | Identifier to flush when flushAll is low |
| hit | output | 1 | Translation succeeded |
| miss | output | 1 | No entry holds the translation |
| fault | output | 1 | Entry found but the access is refused |
| pfn | output | PFN_W | Frame number on hit, else zero |
| rspVpn | output | VPN_W | Echoed page on miss or fault, else zero |
| rspMode | output | 2 | Echoed access kind on miss or fault, else zero |

## Verification
Lookups run every access kind against entries with mixed rights, so a swapped or ignored right bit shows up as a wrong hit or fault. The same page is installed under two identifiers and then flushed by identifier, which tells per-address-space tagging apart from page-only matching. A fill of all entries followed by hits and further fills pins down the rotating victim and its skip of the last-hit entry, and a lookup sweep shows exactly which page was evicted. Lookups, fills and flushes share cycles so that the order in which they apply is visible.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RSVD  = 2'b11
  } accMode_t;

  // right bit positions inside an entry's permission field
  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;
  localparam int PERM_EX = 2;
  localparam int PERM_W  = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic lookHit;
    logic lookMiss;
    logic lookFault;
    logic doFill;
    logic wipeAll;
    logic wipeAsid;
  } tlbStrobe_t;

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 48,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] occ,
  input  logic [VPN_W-1:0]   vpnTab  [ENTRIES],
  input  logic [ASID_W-1:0]  asidTab [ENTRIES],
  input  logic [VPN_W-1:0]   keyVpn,
  input  logic [ASID_W-1:0]  keyAsid,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);

  logic [ENTRIES-1:0] hitVec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hitVec[g] = occ[g] && (vpnTab[g] == keyVpn) && (asidTab[g] == keyAsid);
  end

  // lowest index wins
  always_comb begin
    found = |hitVec;
    idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 48,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  tlbStrobe_t         strobe,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [VPN_W-1:0]   lkVpn,
  input  logic [ASID_W-1:0]  lkAsid,
  input  logic [1:0]         lkMode,
  input  logic [VPN_W-1:0]   fillVpn,
  input  logic [ASID_W-1:0]  fillAsid,
  input  logic [PFN_W-1:0]   fillPfn,
  input  logic [PERM_W-1:0]  fillPerm,
  input  logic               fillPresent,
  input  logic [ASID_W-1:0]  flushAsid,
  output logic               lkFound,
  output logic [IDX_W-1:0]   lkIdx,
  output logic               lkPresent,
  output logic [PERM_W-1:0]  lkPerm,
  output logic               fillFound,
  output logic [IDX_W-1:0]   fillIdx,
  output logic               freeAny,
  output logic [IDX_W-1:0]   freeIdx,
  output logic [ENTRIES-1:0] occVec,
  output logic [PFN_W-1:0]   pfnQ,
  output logic [VPN_W-1:0]   rspVpnQ,
  output logic [1:0]         rspModeQ
);

  logic [ENTRIES-1:0] occQ;
  logic [ENTRIES-1:0] presQ;
  logic [PERM_W-1:0]  permQ [ENTRIES];
  logic [VPN_W-1:0]   vpnQ  [ENTRIES];
  logic [ASID_W-1:0]  asidQ [ENTRIES];
  logic [PFN_W-1:0]   pfnTab[ENTRIES];

  assign occVec = occQ;

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) lookMatch (
    .occ(occQ), .vpnTab(vpnQ), .asidTab(asidQ),
    .keyVpn(lkVpn), .keyAsid(lkAsid),
    .found(lkFound), .idx(lkIdx)
  );

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) fillMatch (
    .occ(occQ), .vpnTab(vpnQ), .asidTab(asidQ),
    .keyVpn(fillVpn), .keyAsid(fillAsid),
    .found(fillFound), .idx(fillIdx)
  );

  assign lkPresent = presQ[lkIdx];
  assign lkPerm    = permQ[lkIdx];

  // lowest unoccupied slot
  always_comb begin
    freeAny = ~&occQ;
    freeIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!occQ[i]) freeIdx = IDX_W'(i);
    end
  end

  // occupancy: flush first, fill written last so it survives
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      occQ <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (strobe.wipeAll || (strobe.wipeAsid && asidQ[i] == flushAsid))
          occQ[i] <= 1'b0;
      end
      if (strobe.doFill) occQ[wrIdx] <= 1'b1;
    end
  end

  // payload, meaningful only while occupied
  always_ff @(posedge clk) begin
    if (strobe.doFill) begin
      vpnQ[wrIdx]   <= fillVpn;
      asidQ[wrIdx]  <= fillAsid;
      pfnTab[wrIdx] <= fillPfn;
      permQ[wrIdx]  <= fillPerm;
      presQ[wrIdx]  <= fillPresent;
    end
  end

  // response registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pfnQ     <= '0;
      rspVpnQ  <= '0;
      rspModeQ <= '0;
    end else begin
      pfnQ <= strobe.lookHit ? pfnTab[lkIdx] : '0;
      if (strobe.lookMiss || strobe.lookFault) begin
        rspVpnQ  <= lkVpn;
        rspModeQ <= lkMode;
      end else begin
        rspVpnQ  <= '0;
        rspModeQ <= '0;
      end
    end
  end

endmodule

// File: rtl/tlb_control.sv
module tlb_control
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 48,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  input  logic [1:0]        lkMode,
  input  logic              fillValid,
  input  logic              flushValid,
  input  logic              flushAll,
  input  logic              lkFound,
  input  logic [IDX_W-1:0]  lkIdx,
  input  logic              lkPresent,
  input  logic [PERM_W-1:0] lkPerm,
  input  logic              fillFound,
  input  logic [IDX_W-1:0]  fillIdx,
  input  logic              freeAny,
  input  logic [IDX_W-1:0]  freeIdx,
  output tlbStrobe_t        strobe,
  output logic [IDX_W-1:0]  wrIdx,
  output logic              hitQ,
  output logic              missQ,
  output logic              faultQ
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic             modeOk;
  logic [IDX_W-1:0] victPtrQ;
  logic [IDX_W-1:0] lastHitQ;
  logic             lastHitValidQ;
  logic [IDX_W-1:0] rotCand;
  logic             evict;

  function automatic logic [IDX_W-1:0] stepIdx(input logic [IDX_W-1:0] x);
    return (x == LAST_IDX) ? '0 : x + 1'b1;
  endfunction

  always_comb begin
    unique case (accMode_t'(lkMode))
      ACC_READ:  modeOk = lkPerm[PERM_RD];
      ACC_WRITE: modeOk = lkPerm[PERM_WR];
      ACC_EXEC:  modeOk = lkPerm[PERM_EX];
      default:   modeOk = 1'b0;
    endcase
  end

  always_comb begin
    strobe.lookHit   = lkValid && lkFound && lkPresent && modeOk;
    strobe.lookFault = lkValid && lkFound && !(lkPresent && modeOk);
    strobe.lookMiss  = lkValid && !lkFound;
    strobe.doFill    = fillValid;
    strobe.wipeAll   = flushValid && flushAll;
    strobe.wipeAsid  = flushValid && !flushAll;
  end

  // not-last-used rotating victim
  always_comb begin
    rotCand = victPtrQ;
    if (lastHitValidQ && victPtrQ == lastHitQ) rotCand = stepIdx(victPtrQ);
    evict = fillValid && !fillFound && !freeAny;
    if (fillFound)    wrIdx = fillIdx;
    else if (freeAny) wrIdx = freeIdx;
    else              wrIdx = rotCand;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      victPtrQ      <= '0;
      lastHitQ      <= '0;
      lastHitValidQ <= 1'b0;
      hitQ          <= 1'b0;
      missQ         <= 1'b0;
      faultQ        <= 1'b0;
    end else begin
      hitQ   <= strobe.lookHit;
      missQ  <= strobe.lookMiss;
      faultQ <= strobe.lookFault;
      if (evict) victPtrQ <= stepIdx(rotCand);
      if (strobe.lookHit) begin
        lastHitQ      <= lkIdx;
        lastHitValidQ <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/tlb_top.sv
module tlb_top
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 48,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ASID_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  input  logic [VPN_W-1:0]  lkVpn,
  input  logic [ASID_W-1:0] lkAsid,
  input  logic [1:0]        lkMode,
  input  logic              fillValid,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [ASID_W-1:0] fillAsid,
  input  logic [PFN_W-1:0]  fillPfn,
  input  logic              fillRead,
  input  logic              fillWrite,
  input  logic              fillExec,
  input  logic              fillPresent,
  input  logic              flushValid,
  input  logic              flushAll,
  input  logic [ASID_W-1:0] flushAsid,
  output logic              hit,
  output logic              miss,
  output logic              fault,
  output logic [PFN_W-1:0]  pfn,
  output logic [VPN_W-1:0]  rspVpn,
  output logic [1:0]        rspMode
);

  localparam int IDX_W = $clog2(ENTRIES);

  tlbStrobe_t         strobe;
  logic [IDX_W-1:0]   wrIdx;
  logic               lkFound;
  logic [IDX_W-1:0]   lkIdx;
  logic               lkPresent;
  logic [PERM_W-1:0]  lkPerm;
  logic               fillFound;
  logic [IDX_W-1:0]   fillIdx;
  logic               freeAny;
  logic [IDX_W-1:0]   freeIdx;
  logic [ENTRIES-1:0] occVec;
  logic [PERM_W-1:0]  fillPerm;

  always_comb begin
    fillPerm          = '0;
    fillPerm[PERM_RD] = fillRead;
    fillPerm[PERM_WR] = fillWrite;
    fillPerm[PERM_EX] = fillExec;
  end

  tlb_control #(.ENTRIES(ENTRIES)) ctrl (
    .clk(clk), .rstN(rstN),
    .lkValid(lkValid), .lkMode(lkMode),
    .fillValid(fillValid), .flushValid(flushValid), .flushAll(flushAll),
    .lkFound(lkFound), .lkIdx(lkIdx), .lkPresent(lkPresent), .lkPerm(lkPerm),
    .fillFound(fillFound), .fillIdx(fillIdx),
    .freeAny(freeAny), .freeIdx(freeIdx),
    .strobe(strobe), .wrIdx(wrIdx),
    .hitQ(hit), .missQ(miss), .faultQ(fault)
  );

  tlb_datapath #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .wrIdx(wrIdx),
    .lkVpn(lkVpn), .lkAsid(lkAsid), .lkMode(lkMode),
    .fillVpn(fillVpn), .fillAsid(fillAsid), .fillPfn(fillPfn),
    .fillPerm(fillPerm), .fillPresent(fillPresent),
    .flushAsid(flushAsid),
    .lkFound(lkFound), .lkIdx(lkIdx), .lkPresent(lkPresent), .lkPerm(lkPerm),
    .fillFound(fillFound), .fillIdx(fillIdx),
    .freeAny(freeAny), .freeIdx(freeIdx),
    .occVec(occVec),
    .pfnQ(pfn), .rspVpnQ(rspVpn), .rspModeQ(rspMode)
  );

endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
  parameter int ENTRIES = 48,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20
) (
  input logic               clk,
  input logic               rstN,
  input logic               lkValid,
  input logic [VPN_W-1:0]   lkVpn,
  input logic [1:0]         lkMode,
  input logic               fillValid,
  input logic               flushValid,
  input logic               flushAll,
  input logic               hit,
  input logic               miss,
  input logic               fault,
  input logic [PFN_W-1:0]   pfn,
  input logic [VPN_W-1:0]   rspVpn,
  input logic [1:0]         rspMode,
  input logic [ENTRIES-1:0] occVec
);

  p_onehot_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({hit, miss, fault}));

  p_answer_r11: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> (hit || miss || fault));

  p_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !(hit || miss || fault));

  p_pfn_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (pfn == '0));

  p_echo_r3: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> ((miss || fault) ? (rspVpn == $past(lkVpn) && rspMode == $past(lkMode))
                                 : (rspVpn == '0 && rspMode == 2'b00)));

  p_rsvd_r4: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && lkMode == 2'b11) |=> !hit);

  p_fill_r7: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |=> (occVec != '0));

  p_flush_r10: assert property (@(posedge clk) disable iff (!rstN)
    (flushValid && flushAll && !fillValid) |=> (occVec == '0));

endmodule

bind tlb_top tlb_checker #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) chk (
  .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkVpn(lkVpn), .lkMode(lkMode),
  .fillValid(fillValid), .flushValid(flushValid), .flushAll(flushAll),
  .hit(hit), .miss(miss), .fault(fault), .pfn(pfn),
  .rspVpn(rspVpn), .rspMode(rspMode), .occVec(occVec)
);

// File: tb/tlb_top_test.sv
module tlb_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int ENT    = 48;
  localparam int VPN_W  = 20;
  localparam int PFN_W  = 20;
  localparam int ASID_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lkValid = 0;
  logic [VPN_W-1:0] lkVpn = '0;
  logic [ASID_W-1:0] lkAsid = '0;
  logic [1:0] lkMode = '0;
  logic fillValid = 0;
  logic [VPN_W-1:0] fillVpn = '0;
  logic [ASID_W-1:0] fillAsid = '0;
  logic [PFN_W-1:0] fillPfn = '0;
  logic fillRead = 0, fillWrite = 0, fillExec = 0, fillPresent = 0;
  logic flushValid = 0, flushAll = 0;
  logic [ASID_W-1:0] flushAsid = '0;
  logic hit, miss, fault;
  logic [PFN_W-1:0] pfn;
  logic [VPN_W-1:0] rspVpn;
  logic [1:0] rspMode;

  tlb_top #(.ENTRIES(ENT), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) uut (
    .clk(clk), .rstN(rstN),
    .lkValid(lkValid), .lkVpn(lkVpn), .lkAsid(lkAsid), .lkMode(lkMode),
    .fillValid(fillValid), .fillVpn(fillVpn), .fillAsid(fillAsid), .fillPfn(fillPfn),
    .fillRead(fillRead), .fillWrite(fillWrite), .fillExec(fillExec), .fillPresent(fillPresent),
    .flushValid(flushValid), .flushAll(flushAll), .flushAsid(flushAsid),
    .hit(hit), .miss(miss), .fault(fault), .pfn(pfn), .rspVpn(rspVpn), .rspMode(rspMode)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int vectors = 0;
  int fails = 0;
  bit running = 0;
  string curReq = "R1";

  // reference model state
  bit mOcc[ENT], mPres[ENT], mRd[ENT], mWr[ENT], mEx[ENT];
  logic [VPN_W-1:0] mVpn[ENT];
  logic [ASID_W-1:0] mAsid[ENT];
  logic [PFN_W-1:0] mPfn[ENT];
  int mLast = -1;
  int mPtr = 0;
  bit eHit = 0, eMiss = 0, eFault = 0;
  logic [PFN_W-1:0] ePfn = '0;
  logic [VPN_W-1:0] eVpn = '0;
  logic [1:0] eMode = '0;

  always @(posedge clk) begin
    int lm, fm, fr, vic;
    bit ok;
    if (!rstN) begin
      for (int i = 0; i < ENT; i++) mOcc[i] = 0;
      mLast = -1; mPtr = 0;
      eHit = 0; eMiss = 0; eFault = 0; ePfn = '0; eVpn = '0; eMode = '0;
    end else begin
      lm = -1; fm = -1; fr = -1;
      for (int i = 0; i < ENT; i++) begin
        if (lm < 0 && mOcc[i] && mVpn[i] == lkVpn && mAsid[i] == lkAsid) lm = i;
        if (fm < 0 && mOcc[i] && mVpn[i] == fillVpn && mAsid[i] == fillAsid) fm = i;
        if (fr < 0 && !mOcc[i]) fr = i;
      end
      eHit = 0; eMiss = 0; eFault = 0; ePfn = '0; eVpn = '0; eMode = '0;
      if (lkValid) begin
        if (lm < 0) begin
          eMiss = 1; eVpn = lkVpn; eMode = lkMode;
        end else begin
          case (lkMode)
            2'd0: ok = mRd[lm];
            2'd1: ok = mWr[lm];
            2'd2: ok = mEx[lm];
            default: ok = 0;
          endcase
          ok = ok && mPres[lm];
          if (ok) begin eHit = 1; ePfn = mPfn[lm]; end
          else begin eFault = 1; eVpn = lkVpn; eMode = lkMode; end
        end
      end
      vic = -1;
      if (fillValid) begin
        if (fm >= 0) vic = fm;
        else if (fr >= 0) vic = fr;
        else begin
          vic = mPtr;
          if (vic == mLast) vic = (vic + 1) % ENT;
          mPtr = (vic + 1) % ENT;
        end
      end
      if (eHit) mLast = lm;
      if (flushValid)
        for (int i = 0; i < ENT; i++)
          if (flushAll || mAsid[i] == flushAsid) mOcc[i] = 0;
      if (vic >= 0) begin
        mOcc[vic] = 1; mVpn[vic] = fillVpn; mAsid[vic] = fillAsid; mPfn[vic] = fillPfn;
        mRd[vic] = fillRead; mWr[vic] = fillWrite; mEx[vic] = fillExec; mPres[vic] = fillPresent;
      end
    end
  end

  always @(negedge clk) begin
    if (running) begin
      vectors++;
      if (hit !== eHit || miss !== eMiss || fault !== eFault || pfn !== ePfn ||
          rspVpn !== eVpn || rspMode !== eMode) begin
        fails++;
        $display("FAIL %s: hmf=%b%b%b pfn=%h vpn=%h mode=%0d expected hmf=%b%b%b pfn=%h vpn=%h mode=%0d",
                 curReq, hit, miss, fault, pfn, rspVpn, rspMode,
                 eHit, eMiss, eFault, ePfn, eVpn, eMode);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    lkValid = 0; fillValid = 0; flushValid = 0;
  endtask

  task automatic setLk(input int vpn, input int asid, input int mode);
    lkValid = 1; lkVpn = VPN_W'(vpn); lkAsid = ASID_W'(asid); lkMode = 2'(mode);
  endtask

  task automatic setFill(input int vpn, input int asid, input int pf,
                         input bit r, input bit w, input bit x, input bit p);
    fillValid = 1; fillVpn = VPN_W'(vpn); fillAsid = ASID_W'(asid); fillPfn = PFN_W'(pf);
    fillRead = r; fillWrite = w; fillExec = x; fillPresent = p;
  endtask

  task automatic setFlush(input bit all, input int asid);
    flushValid = 1; flushAll = all; flushAsid = ASID_W'(asid);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: run did not complete, expected end of stimulus");
    finishRun();
  end

  initial begin
    // R1: outputs quiet during reset
    repeat (3) @(negedge clk);
    vectors++;
    if ({hit, miss, fault} !== 3'b000 || pfn !== '0) begin
      fails++;
      $display("FAIL R1: hmf=%b%b%b pfn=%h expected 000 pfn=0", hit, miss, fault, pfn);
    end
    rstN = 1;
    running = 1;
    tick();

    curReq = "R1"; setLk(5, 1, 0); tick();
    curReq = "R3"; setLk(9, 1, 2); tick();

    // R7: fill free slots with mixed rights
    curReq = "R7";
    setFill('h100, 1, 'h1100, 1, 0, 0, 1); tick();
    setFill('h101, 1, 'h1101, 1, 1, 0, 1); tick();
    setFill('h102, 1, 'h1102, 0, 0, 1, 1); tick();
    setFill('h103, 1, 'h1103, 1, 1, 1, 0); tick();
    tick();

    curReq = "R2";
    setLk('h100, 1, 0); tick();
    setLk('h101, 1, 1); tick();
    setLk('h102, 1, 2); tick();
    curReq = "R4";
    setLk('h100, 1, 1); tick();
    setLk('h100, 1, 2); tick();
    setLk('h102, 1, 0); tick();
    setLk('h101, 1, 3); tick();
    curReq = "R5";
    for (int m = 0; m < 4; m++) begin setLk('h103, 1, m); tick(); end

    curReq = "R6";
    setLk('h100, 2, 0); tick();
    setFill('h100, 2, 'h2200, 1, 1, 1, 1); tick();
    setLk('h100, 2, 1); tick();
    setLk('h100, 1, 0); tick();

    curReq = "R9";
    setFill('h100, 1, 'h1999, 1, 1, 0, 1); tick();
    setLk('h100, 1, 1); tick();
    setLk('h100, 1, 0); tick();

    curReq = "R11";
    tick(); tick();
    setLk('h104, 1, 0); setFill('h104, 1, 'h1104, 1, 0, 0, 1); tick();
    setLk('h104, 1, 0); tick();

    curReq = "R10";
    setFlush(0, 2); tick();
    setLk('h100, 2, 0); tick();
    setLk('h101, 1, 1); tick();
    setLk('h101, 1, 0); setFlush(1, 0); setFill('h105, 1, 'h1105, 1, 1, 1, 1); tick();
    setLk('h101, 1, 0); tick();
    setLk('h105, 1, 2); tick();
    setFlush(1, 0); tick();
    setLk('h105, 1, 2); tick();

    // R8: fill all, then evict with last-hit skipping
    curReq = "R8";
    for (int i = 0; i < ENT; i++) begin setFill('h200 + i, 3, 'h3000 + i, 1, 1, 1, 1); tick(); end
    setLk('h200, 3, 0); tick();
    setFill('h300, 3, 'h3300, 1, 1, 1, 1); tick();
    setFill('h301, 3, 'h3301, 1, 1, 1, 1); tick();
    setLk('h203, 3, 0); tick();
    setFill('h302, 3, 'h3302, 1, 1, 1, 1); tick();
    setLk('h205, 3, 0); setFill('h303, 3, 'h3303, 1, 1, 1, 1); tick();
    for (int i = 0; i < ENT; i++) begin setLk('h200 + i, 3, 0); tick(); end
    for (int i = 0; i < 4; i++) begin setLk('h300 + i, 3, 1); tick(); end

    curReq = "R11";
    tick(); tick();
    running = 0;
    finishRun();
  end

endmodule